// File: doc/BRIEF.md
# Receiver Link-Lock Recovery Watchdog

This block sits next to a serial transceiver's receive path and gets the clock-data-recovery loop locked again when lock is lost. The usual case is a cable plugged in after the device is already running, with no power cycle. The block watches the parallel words the receiver delivers and compares each one against a fixed alignment word. When that word keeps arriving, it declares the link locked.

Some words mean the input is floating or the recovered clock is slipping: words made entirely of alternating bits, in either phase. The block never treats such words as data. A change from one alternating phase to the other between consecutive words shows a bit slip, and the block answers it with an immediate receiver reset. If the alignment word does not arrive within a timeout window, the block pulses the receiver reset and starts the window again. It keeps doing this for as long as the link fails to lock. A saturating counter of these retries is available for debug.

While the line is reported idle, the block asks the recovery loop to hold its state. It releases the hold one cycle after activity returns.

Top module: `rx_lock_guard`

## Requirements
- R1: While `srst` is high and on the first cycle after it falls, `rx_reset` is 1, `locked` is 0, `retry_cnt` is 0 and `cdr_hold` is 1.
- R2: Every receiver reset pulse keeps `rx_reset` high for exactly RST_CYC clock cycles once `srst` is low.
- R3: A word counts as a match when `rx_valid` is 1, `rx_idle` is 0 and `rx_word` equals KNOWN_WORD. `locked` rises on the cycle after the LOCK_CNT-th match in a row. Any other valid non-idle word before then restarts the run of matches.
- R4: In the search phase a timer counts cycles since the last match or since the end of the last pulse. When TIMEOUT_CYC cycles pass with no match, a reset pulse starts on the next cycle.
- R5: Reset-and-wait repeats with no limit. Each pulse started by a timeout or a slip adds one to `retry_cnt`, which saturates at 2^RETRY_W-1. The start-up pulse does not count.
- R6: A valid non-idle word whose every 4-bit nibble is 0xA, or whose every nibble is 0x5, never counts as a match. `locked` is 0 on the next cycle.
- R7: Two consecutive valid non-idle words that are the two different alternating forms (0xA.. then 0x5.., or the reverse) start a reset pulse on the next cycle.
- R8: `cdr_hold` equals `rx_idle` delayed by one cycle. While `rx_idle` is 1, words are ignored and `locked` is 0 on the next cycle.
- R9: `locked` is never 1 while `rx_reset` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive parallel clock |
| srst | input | 1 | Synchronous active-high reset |
| rx_word | input | DATA_W | Received parallel word |
| rx_valid | input | 1 | Word strobe |
| rx_idle | input | 1 | Line idle / electrical idle indicator |
| rx_reset | output | 1 | Receiver reset pulse |
| cdr_hold | output | 1 | Hold request to the clock recovery loop |
| locked | output | 1 | Link locked status |
| retry_cnt | output | RETRY_W | Saturating count of retry pulses |

## Verification
Slip detection is tested with a 0x5.. word followed by a 0xA.. word. A design that only looked at the 0xA.. form, or that compared each word with the stored phase without checking it differs, would issue no reset. The lock run is broken by one foreign word. A design counting total rather than consecutive matches would lock two words early. The timer is restarted by a match two cycles before expiry. An off-by-one, or a timer that ignores matches, shows up as an early or missing pulse. Known words sent during idle must not build lock. The retry counter is driven past its top value to catch wrap-around.

// File: rtl/rlg_pkg.sv
package rlg_pkg;
   typedef enum logic {
      ST_PULSE  = 1'b0,
      ST_SEARCH = 1'b1
   } rlg_state_e;

   typedef enum logic [1:0] {
      ALT_NONE = 2'd0,
      ALT_HI   = 2'd1,
      ALT_LO   = 2'd2
   } rlg_alt_e;
endpackage

// File: rtl/rlg_word_class.sv
module rlg_word_class #(
   parameter int          DATA_W     = 32,
   parameter logic [DATA_W-1:0] KNOWN_WORD = 32'h3C5A_F00F
) (
   input  logic [DATA_W-1:0] word,
   output logic              is_known,
   output logic              is_alt_hi,
   output logic              is_alt_lo
);
   localparam int NIB_N = DATA_W / 4;

   logic [NIB_N-1:0] nib_hi;
   logic [NIB_N-1:0] nib_lo;

   for (genvar g = 0; g < NIB_N; g++) begin : g_nib
      assign nib_hi[g] = (word[4*g +: 4] == 4'hA);
      assign nib_lo[g] = (word[4*g +: 4] == 4'h5);
   end

   assign is_known  = (word == KNOWN_WORD);
   assign is_alt_hi = &nib_hi;
   assign is_alt_lo = &nib_lo;
endmodule

// File: rtl/rlg_lock_track.sv
module rlg_lock_track #(
   parameter int LOCK_CNT = 4
) (
   input  logic clk,
   input  logic srst,
   input  logic clr,
   input  logic hit,
   input  logic alt,
   input  logic miss,
   output logic locked
);
   localparam int LK_W = $clog2(LOCK_CNT + 1);

   logic [LK_W-1:0] run_q;

   always_ff @(posedge clk) begin
      if (srst || clr || alt) begin
         run_q  <= '0;
         locked <= 1'b0;
      end else if (hit) begin
         if (run_q != LK_W'(LOCK_CNT)) run_q <= run_q + 1'b1;
         if (run_q >= LK_W'(LOCK_CNT - 1)) locked <= 1'b1;
      end else if (miss && !locked) begin
         run_q <= '0;
      end
   end
endmodule

// File: rtl/rlg_sat_cnt.sv
module rlg_sat_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         srst,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   always_ff @(posedge clk) begin
      if (srst)                  cnt <= '0;
      else if (inc && !(&cnt))   cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/rx_lock_guard.sv
module rx_lock_guard
   import rlg_pkg::*;
#(
   parameter int                DATA_W      = 32,
   parameter logic [DATA_W-1:0] KNOWN_WORD  = 32'h3C5A_F00F,
   parameter int                TIMEOUT_CYC = 1024,
   parameter int                RST_CYC     = 16,
   parameter int                LOCK_CNT    = 4,
   parameter int                RETRY_W     = 8
) (
   input  logic              clk,
   input  logic              srst,
   input  logic [DATA_W-1:0] rx_word,
   input  logic              rx_valid,
   input  logic              rx_idle,
   output logic              rx_reset,
   output logic              cdr_hold,
   output logic              locked,
   output logic [RETRY_W-1:0] retry_cnt
);
   localparam int SPAN  = (TIMEOUT_CYC > RST_CYC) ? TIMEOUT_CYC : RST_CYC;
   localparam int CNT_W = $clog2(SPAN + 1);

   if (DATA_W % 4 != 0 || DATA_W < 4) begin : g_bad_w
      $error("rx_lock_guard: DATA_W must be a positive multiple of 4");
   end
   if (RST_CYC < 1 || TIMEOUT_CYC < 2 || LOCK_CNT < 1 || RETRY_W < 1) begin : g_bad_p
      $error("rx_lock_guard: timing parameters out of range");
   end

   rlg_state_e       st_q;
   rlg_alt_e         prev_alt_q;
   rlg_alt_e         cur_alt;
   logic [CNT_W-1:0] cnt_q;
   logic             is_known, is_alt_hi, is_alt_lo;
   logic             word_ok, hit, alt, miss, slip, expire, go_pulse;

   rlg_word_class #(.DATA_W(DATA_W), .KNOWN_WORD(KNOWN_WORD)) u_class (
      .word     (rx_word),
      .is_known (is_known),
      .is_alt_hi(is_alt_hi),
      .is_alt_lo(is_alt_lo)
   );

   always_comb begin
      word_ok = rx_valid && !rx_idle && (st_q == ST_SEARCH);
      hit     = word_ok && is_known;
      alt     = word_ok && (is_alt_hi || is_alt_lo);
      miss    = word_ok && !is_known;
      if (!word_ok)       cur_alt = ALT_NONE;
      else if (is_alt_hi) cur_alt = ALT_HI;
      else if (is_alt_lo) cur_alt = ALT_LO;
      else                cur_alt = ALT_NONE;
      slip     = (cur_alt != ALT_NONE) && (prev_alt_q != ALT_NONE) &&
                 (cur_alt != prev_alt_q);
      expire   = (st_q == ST_SEARCH) && !hit && (cnt_q == CNT_W'(TIMEOUT_CYC - 1));
      go_pulse = (st_q == ST_SEARCH) && (slip || expire);
   end

   always_ff @(posedge clk) begin
      if (srst) begin
         st_q       <= ST_PULSE;
         cnt_q      <= '0;
         prev_alt_q <= ALT_NONE;
         cdr_hold   <= 1'b1;
      end else begin
         cdr_hold <= rx_idle;
         unique case (st_q)
            ST_PULSE: begin
               prev_alt_q <= ALT_NONE;
               if (cnt_q == CNT_W'(RST_CYC - 1)) begin
                  st_q  <= ST_SEARCH;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_SEARCH: begin
               if (word_ok) prev_alt_q <= cur_alt;
               if (go_pulse) begin
                  st_q  <= ST_PULSE;
                  cnt_q <= '0;
               end else if (hit) begin
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: st_q <= ST_PULSE;
         endcase
      end
   end

   assign rx_reset = (st_q == ST_PULSE);

   rlg_lock_track #(.LOCK_CNT(LOCK_CNT)) u_lock (
      .clk   (clk),
      .srst  (srst),
      .clr   (rx_reset || go_pulse || rx_idle),
      .hit   (hit),
      .alt   (alt),
      .miss  (miss),
      .locked(locked)
   );

   rlg_sat_cnt #(.W(RETRY_W)) u_retry (
      .clk (clk),
      .srst(srst),
      .inc (go_pulse),
      .cnt (retry_cnt)
   );
endmodule

// File: rtl/rx_lock_guard_chk.sv
module rx_lock_guard_chk #(
   parameter int                DATA_W     = 32,
   parameter logic [DATA_W-1:0] KNOWN_WORD = 32'h3C5A_F00F,
   parameter int                RETRY_W    = 8
) (
   input logic               clk,
   input logic               srst,
   input logic [DATA_W-1:0]  rx_word,
   input logic               rx_valid,
   input logic               rx_idle,
   input logic               rx_reset,
   input logic               cdr_hold,
   input logic               locked,
   input logic [RETRY_W-1:0] retry_cnt
);
   localparam logic [DATA_W-1:0] PAT_HI = {(DATA_W/4){4'hA}};
   localparam logic [DATA_W-1:0] PAT_LO = {(DATA_W/4){4'h5}};

   // R9
   reset_excludes_lock_chk: assert property (@(posedge clk) disable iff (srst)
      rx_reset |-> !locked);

   // R6
   alt_drops_lock_chk: assert property (@(posedge clk) disable iff (srst)
      (rx_valid && !rx_idle && (rx_word == PAT_HI || rx_word == PAT_LO)) |=> !locked);

   // R3
   lock_needs_match_chk: assert property (@(posedge clk) disable iff (srst)
      $rose(locked) |-> $past(rx_valid && !rx_idle && rx_word == KNOWN_WORD));

   // R8
   hold_follows_idle_chk: assert property (@(posedge clk) disable iff (srst)
      !$past(srst) |-> (cdr_hold == $past(rx_idle)));

   // R8
   idle_clears_lock_chk: assert property (@(posedge clk) disable iff (srst)
      rx_idle |=> !locked);

   // R5
   retry_monotone_chk: assert property (@(posedge clk) disable iff (srst)
      !$past(srst) |-> (retry_cnt >= $past(retry_cnt)));

   // R5
   retry_saturate_chk: assert property (@(posedge clk) disable iff (srst)
      (&retry_cnt) |=> (&retry_cnt));
endmodule

bind rx_lock_guard rx_lock_guard_chk #(
   .DATA_W    (DATA_W),
   .KNOWN_WORD(KNOWN_WORD),
   .RETRY_W   (RETRY_W)
) u_chk (
   .clk      (clk),
   .srst     (srst),
   .rx_word  (rx_word),
   .rx_valid (rx_valid),
   .rx_idle  (rx_idle),
   .rx_reset (rx_reset),
   .cdr_hold (cdr_hold),
   .locked   (locked),
   .retry_cnt(retry_cnt)
);

// File: tb/rx_lock_guard_bench.sv
module rx_lock_guard_bench;
   localparam int          DW    = 32;
   localparam logic [31:0] KNOWN = 32'h3C5A_F00F;
   localparam logic [31:0] W_HI  = 32'hAAAA_AAAA;
   localparam logic [31:0] W_LO  = 32'h5555_5555;
   localparam logic [31:0] JUNK  = 32'h1234_5678;
   localparam int          TO    = 20;
   localparam int          RC    = 4;
   localparam int          LC    = 3;
   localparam int          RW    = 3;
   localparam int          RMAX  = (1 << RW) - 1;

   logic          clk = 1'b0;
   logic          srst = 1'b1;
   logic [DW-1:0] rx_word = '0;
   logic          rx_valid = 1'b0;
   logic          rx_idle = 1'b0;
   logic          rx_reset, cdr_hold, locked;
   logic [RW-1:0] retry_cnt;

   int n_chk = 0;
   int n_err = 0;
   int exp_retry = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   rx_lock_guard #(
      .DATA_W(DW), .KNOWN_WORD(KNOWN), .TIMEOUT_CYC(TO),
      .RST_CYC(RC), .LOCK_CNT(LC), .RETRY_W(RW)
   ) u_rx_lock_guard (
      .clk(clk), .srst(srst), .rx_word(rx_word), .rx_valid(rx_valid),
      .rx_idle(rx_idle), .rx_reset(rx_reset), .cdr_hold(cdr_hold),
      .locked(locked), .retry_cnt(retry_cnt)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step(input logic [31:0] w, input logic v, input logic idl);
      rx_word  = w;
      rx_valid = v;
      rx_idle  = idl;
      @(posedge clk);
      #1;
   endtask

   task automatic bump_retry();
      if (exp_retry < RMAX) exp_retry++;
   endtask

   // counts cycles until rx_reset falls; returns pulse length
   task automatic ride_pulse(output int n);
      n = 0;
      while (rx_reset && n < 1000) begin
         step('0, 1'b0, 1'b0);
         n++;
      end
   endtask

   task automatic t_reset();
      int n;
      srst = 1'b1;
      step('0, 1'b0, 1'b0);
      step('0, 1'b0, 1'b0);
      check("R1 rx_reset in reset", int'(rx_reset), 1);
      check("R1 locked in reset", int'(locked), 0);
      check("R1 retry in reset", int'(retry_cnt), 0);
      check("R1 cdr_hold in reset", int'(cdr_hold), 1);
      srst = 1'b0;
      check("R1 rx_reset after release", int'(rx_reset), 1);
      ride_pulse(n);
      check("R2 start-up pulse length", n, RC);
      check("R8 cdr_hold released", int'(cdr_hold), 0);
   endtask

   task automatic t_lock();
      for (int i = 0; i < LC - 1; i++) step(KNOWN, 1'b1, 1'b0);
      check("R3 not locked before run", int'(locked), 0);
      step(KNOWN, 1'b1, 1'b0);
      check("R3 locked after run", int'(locked), 1);
   endtask

   task automatic t_consec();
      step(W_HI, 1'b1, 1'b0);
      check("R6 alt word drops lock", int'(locked), 0);
      check("R6 alt word no pulse", int'(rx_reset), 0);
      step(KNOWN, 1'b1, 1'b0);
      step(KNOWN, 1'b1, 1'b0);
      step(JUNK, 1'b1, 1'b0);
      step(KNOWN, 1'b1, 1'b0);
      step(KNOWN, 1'b1, 1'b0);
      check("R3 broken run stays unlocked", int'(locked), 0);
      step(KNOWN, 1'b1, 1'b0);
      check("R3 locked after fresh run", int'(locked), 1);
   endtask

   task automatic t_idle();
      step(KNOWN, 1'b1, 1'b1);
      check("R8 hold during idle", int'(cdr_hold), 1);
      check("R8 idle drops lock", int'(locked), 0);
      for (int i = 0; i < LC; i++) step(KNOWN, 1'b1, 1'b1);
      check("R8 idle words ignored", int'(locked), 0);
      step('0, 1'b0, 1'b0);
      check("R8 hold released", int'(cdr_hold), 0);
      for (int i = 0; i < LC; i++) step(KNOWN, 1'b1, 1'b0);
      check("R3 relock after idle", int'(locked), 1);
   endtask

   task automatic t_timer_restart();
      int pre;
      pre = 0;
      for (int i = 0; i < TO - 2; i++) begin
         step('0, 1'b0, 1'b0);
         if (rx_reset) pre++;
      end
      step(KNOWN, 1'b1, 1'b0);
      for (int i = 0; i < TO - 1; i++) begin
         step('0, 1'b0, 1'b0);
         if (rx_reset) pre++;
      end
      check("R4 match restarts timer", pre, 0);
      step('0, 1'b0, 1'b0);
      bump_retry();
      check("R4 timeout pulse", int'(rx_reset), 1);
      check("R9 lock dropped in pulse", int'(locked), 0);
      check("R5 retry after timeout", int'(retry_cnt), exp_retry);
   endtask

   task automatic t_slip();
      int n;
      ride_pulse(n);
      check("R2 retry pulse length", n, RC);
      for (int i = 0; i < LC; i++) step(KNOWN, 1'b1, 1'b0);
      step(W_LO, 1'b1, 1'b0);
      check("R6 low alt drops lock", int'(locked), 0);
      check("R7 single alt no pulse", int'(rx_reset), 0);
      step(W_HI, 1'b1, 1'b0);
      bump_retry();
      check("R7 slip pulse", int'(rx_reset), 1);
      check("R5 retry after slip", int'(retry_cnt), exp_retry);
   endtask

   task automatic t_timeout();
      int n;
      ride_pulse(n);
      n = 0;
      while (!rx_reset && n < 1000) begin
         step('0, 1'b0, 1'b0);
         n++;
      end
      bump_retry();
      check("R4 timeout window", n, TO);
      check("R5 retry count", int'(retry_cnt), exp_retry);
      for (int k = 0; k < RMAX + 2; k++) begin
         ride_pulse(n);
         n = 0;
         while (!rx_reset && n < 1000) begin
            step('0, 1'b0, 1'b0);
            n++;
         end
         bump_retry();
      end
      check("R5 retry saturates", int'(retry_cnt), RMAX);
      check("R5 retries continue", int'(rx_reset), 1);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual 0 expected 1");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_lock();
      t_consec();
      t_idle();
      t_timer_restart();
      t_slip();
      t_timeout();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule